// File: doc/BRIEF.md
# Cipher Extension Register File

This block is the operand store of a block-cipher functional unit that sits beside a RISC integer pipeline. It holds ten 32-bit words. Words 0 and 1 carry the 64-bit data block, with word 0 as the upper half and word 1 as the lower half. Words 2 to 5 carry a 128-bit key. Words 6 to 9 carry four cipher constants, which take fixed values at reset so that software never has to load them.

Software loads the block and the key one word at a time through an addressed write port. The cipher datapath writes its 64-bit result back into words 0 and 1 in a single cycle through a second port. Between round pairs the datapath issues a rotate command. This command cycles the key group and the constant group in place, so that the next round keys can be derived from the same word positions.

All ten words are always visible on a flat output bus. One further port returns a single word selected by an address. Both read paths are combinational. A request that combines an addressed write with either the result write or the rotate command is illegal. The block flags it and keeps the datapath's operation.

Top module: `cxrf_top`

## Requirements
- R1: While reset is asserted, and after it is released, words 0 to 5 read zero and `errFlag` is 0. Word 6+i equals `CONST_INIT[32*i +: 32]` for i = 0..3 (default `CONST_INIT` = 128'h0123456789ABCDEFFEDCBA9876543210).
- R2: When `wrEn` is high, with `pairEn` and `rotEn` low and `wrAddr` in 0..5, word `wrAddr` takes `wrData` at the next rising clock edge. No other word changes.
- R3: An addressed write with `wrAddr` in 6..15 changes no word and does not raise `errFlag`.
- R4: When `pairEn` is high, word 0 takes `pairData[63:32]` and word 1 takes `pairData[31:0]` at the next edge.
- R5: When `rotEn` is high, the key group rotates upward at the next edge: word k takes the old word k+1 for k = 2..4, and word 5 takes the old word 2.
- R6: In the same cycle the constant group rotates in the same way: word k takes the old word k+1 for k = 6..8, and word 9 takes the old word 6. After four rotations both groups are back in their original order.
- R7: A result write and a rotation in the same cycle both take full effect.
- R8: If `wrEn` and `pairEn` are high together, the result write takes place and the addressed write is dropped. `errFlag` is high for the cycle after that edge.
- R9: If `wrEn` and `rotEn` are high together, the rotation takes place and the addressed write is dropped, whatever the address. `errFlag` is high for the cycle after that edge. In all other cycles `errFlag` is low.
- R10: `entryFlat[32*k +: 32]` presents word k with no register between the storage and the bus.
- R11: `rdData` combinationally returns word `rdAddr` for `rdAddr` in 0..9 and returns zero for `rdAddr` in 10..15.
- R12: Asserting reset after rotations and writes returns every word to its R1 value, including the constants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Addressed single-word write request |
| wrAddr | input | 4 | Destination word (low four bits of the destination field) |
| wrData | input | 32 | Addressed write data |
| pairEn | input | 1 | Result write into words 0 and 1 |
| pairData | input | 64 | Result block, upper half to word 0 |
| rotEn | input | 1 | Rotate key and constant groups |
| rdAddr | input | 4 | Addressed read select |
| rdData | output | 32 | Selected word, zero for addresses 10 to 15 |
| entryFlat | output | 320 | All ten words, word k at bits 32*k+31:32*k |
| errFlag | output | 1 | Registered pulse after a conflicting request |

## Verification
The operations that can fall in the same cycle are the addressed write and the datapath's two operations: the result write and the rotation. The bench drives these combinations on purpose. The cases are a legal write alongside a result write, a legal write alongside a rotation (including a target that lies inside the rotating group), a result write together with a rotation, and long random runs where all three requests are independent. A behavioural model decides, for every clock, which of the requests survive, what each word holds and whether the error pulse follows. All ten words, the read port and the flag are compared against that model.

// File: rtl/cxrf_pkg.sv
package cxrf_pkg;
  localparam int NUM_ENT  = 10;
  localparam int IDX_W    = 4;
  localparam int KEY_LO   = 2;
  localparam int CON_LO   = 6;
  localparam int GRP_N    = 4;
  localparam int KEY_HI   = KEY_LO + GRP_N - 1;
  localparam int CON_HI   = CON_LO + GRP_N - 1;
  localparam int WR_LIMIT = CON_LO;

  typedef struct packed {
    logic             wrWord;
    logic [IDX_W-1:0] wrIdx;
    logic             wrPair;
    logic             rotate;
  } cxrfStrobe_t;
endpackage

// File: rtl/cxrf_ctrl.sv
module cxrf_ctrl
  import cxrf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [IDX_W-1:0]     wrAddr,
  input  logic                 pairEn,
  input  logic                 rotEn,
  output cxrfStrobe_t          strobe,
  output logic                 errFlag
);
  localparam logic [IDX_W-1:0] LIMIT_IDX = IDX_W'(WR_LIMIT);

  logic clash;
  logic inRange;

  always_comb begin
    clash         = wrEn && (pairEn || rotEn);
    inRange       = wrAddr < LIMIT_IDX;
    strobe.wrWord = wrEn && !clash && inRange;
    strobe.wrIdx  = wrAddr;
    strobe.wrPair = pairEn;
    strobe.rotate = rotEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errFlag <= 1'b0;
    else       errFlag <= clash;
  end
endmodule

// File: rtl/cxrf_dp.sv
module cxrf_dp
  import cxrf_pkg::*;
#(
  parameter int                    WORD_W     = 32,
  parameter logic [4*WORD_W-1:0]   CONST_INIT = 128'h0123456789ABCDEFFEDCBA9876543210
)(
  input  logic                      clk,
  input  logic                      rstN,
  input  cxrfStrobe_t               strobe,
  input  logic [WORD_W-1:0]         wrData,
  input  logic [2*WORD_W-1:0]       pairData,
  input  logic [IDX_W-1:0]          rdAddr,
  output logic [NUM_ENT*WORD_W-1:0] entryFlat,
  output logic [WORD_W-1:0]         rdData
);
  localparam logic [IDX_W-1:0] ENT_LIMIT = IDX_W'(NUM_ENT);

  for (genvar k = 0; k < NUM_ENT; k++) begin : gEnt
    logic [WORD_W-1:0] q;
    logic              hit;
    assign hit = strobe.wrWord && (strobe.wrIdx == IDX_W'(k));
    assign entryFlat[k*WORD_W +: WORD_W] = q;

    if (k < KEY_LO) begin : gBlk
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              q <= '0;
        else if (strobe.wrPair) q <= pairData[(KEY_LO-1-k)*WORD_W +: WORD_W];
        else if (hit)           q <= wrData;
      end
    end else if (k <= KEY_HI) begin : gKey
      localparam int SRC = (k == KEY_HI) ? KEY_LO : k + 1;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              q <= '0;
        else if (strobe.rotate) q <= entryFlat[SRC*WORD_W +: WORD_W];
        else if (hit)           q <= wrData;
      end
    end else begin : gCon
      localparam int SRC = (k == CON_HI) ? CON_LO : k + 1;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              q <= CONST_INIT[(k-CON_LO)*WORD_W +: WORD_W];
        else if (strobe.rotate) q <= entryFlat[SRC*WORD_W +: WORD_W];
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (rdAddr < ENT_LIMIT) rdData = entryFlat[int'(rdAddr)*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/cxrf_top.sv
module cxrf_top
  import cxrf_pkg::*;
#(
  parameter int                  WORD_W     = 32,
  parameter logic [4*WORD_W-1:0] CONST_INIT = 128'h0123456789ABCDEFFEDCBA9876543210
)(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [IDX_W-1:0]          wrAddr,
  input  logic [WORD_W-1:0]         wrData,
  input  logic                      pairEn,
  input  logic [2*WORD_W-1:0]       pairData,
  input  logic                      rotEn,
  input  logic [IDX_W-1:0]          rdAddr,
  output logic [WORD_W-1:0]         rdData,
  output logic [NUM_ENT*WORD_W-1:0] entryFlat,
  output logic                      errFlag
);
  cxrfStrobe_t strobe;

  cxrf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .pairEn(pairEn), .rotEn(rotEn), .strobe(strobe), .errFlag(errFlag)
  );

  cxrf_dp #(.WORD_W(WORD_W), .CONST_INIT(CONST_INIT)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .pairData(pairData), .rdAddr(rdAddr), .entryFlat(entryFlat), .rdData(rdData)
  );
endmodule

// File: rtl/cxrf_chk.sv
module cxrf_chk
  import cxrf_pkg::*;
#(
  parameter int WORD_W = 32
)(
  input logic                      clk,
  input logic                      rstN,
  input logic                      wrEn,
  input logic [IDX_W-1:0]          wrAddr,
  input logic [WORD_W-1:0]         wrData,
  input logic                      pairEn,
  input logic [2*WORD_W-1:0]       pairData,
  input logic                      rotEn,
  input logic [IDX_W-1:0]          rdAddr,
  input logic [WORD_W-1:0]         rdData,
  input logic [NUM_ENT*WORD_W-1:0] entryFlat,
  input logic                      errFlag
);
  // R4
  pair_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    pairEn |=> entryFlat[2*WORD_W-1:0] == {$past(pairData[WORD_W-1:0]), $past(pairData[2*WORD_W-1:WORD_W])});

  // R5
  key_rotate_chk: assert property (@(posedge clk) disable iff (!rstN)
    rotEn |=> entryFlat[2*WORD_W +: WORD_W] == $past(entryFlat[3*WORD_W +: WORD_W])
           && entryFlat[5*WORD_W +: WORD_W] == $past(entryFlat[2*WORD_W +: WORD_W]));

  // R6
  const_rotate_chk: assert property (@(posedge clk) disable iff (!rstN)
    rotEn |=> entryFlat[9*WORD_W +: WORD_W] == $past(entryFlat[6*WORD_W +: WORD_W]));

  // R6
  const_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rotEn |=> $stable(entryFlat[NUM_ENT*WORD_W-1:CON_LO*WORD_W]));

  // R3
  high_addr_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !pairEn && !rotEn && wrAddr >= IDX_W'(WR_LIMIT)) |=> $stable(entryFlat) && !errFlag);

  // R8
  pair_clash_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && pairEn) |=> errFlag);

  // R9
  rot_clash_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && rotEn && !pairEn) |=> errFlag && $stable(entryFlat[2*WORD_W-1:0]));

  // R9
  no_clash_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && (pairEn || rotEn)) |=> !errFlag);

  // R11
  read_oob_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr >= IDX_W'(NUM_ENT)) |-> rdData == '0);
endmodule

bind cxrf_top cxrf_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/cxrf_top_tb.sv
`timescale 1ns/1ps
module cxrf_top_tb;
  localparam logic [127:0] CINIT = 128'h0123456789ABCDEFFEDCBA9876543210;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [3:0]   wrAddr = '0;
  logic [31:0]  wrData = '0;
  logic         pairEn = 1'b0;
  logic [63:0]  pairData = '0;
  logic         rotEn = 1'b0;
  logic [3:0]   rdAddr = '0;
  logic [31:0]  rdData;
  logic [319:0] entryFlat;
  logic         errFlag;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [31:0] model [10];
  logic        modelErr;

  always #10 clk = ~clk;

  cxrf_top u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pairEn(pairEn), .pairData(pairData), .rotEn(rotEn), .rdAddr(rdAddr),
    .rdData(rdData), .entryFlat(entryFlat), .errFlag(errFlag)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int k = 0; k < 10; k++) model[k] = (k >= 6) ? CINIT[(k-6)*32 +: 32] : 32'h0;
    modelErr = 1'b0;
  endtask

  function automatic logic [31:0] expRead(input logic [3:0] a);
    return (a < 4'd10) ? model[a] : 32'h0;
  endfunction

  task automatic compareAll(input string tag);
    for (int k = 0; k < 10; k++)
      chk(tag, $sformatf("word%0d", k), entryFlat[k*32 +: 32], model[k]);
    chk(tag, "rdData", rdData, expRead(rdAddr));
    chk(tag, "errFlag", {31'h0, errFlag}, {31'h0, modelErr});
  endtask

  // One clock: inputs applied now (after a falling edge), model updated at the
  // rising edge, outputs compared at the next falling edge.
  task automatic step(input logic w, input logic [3:0] a, input logic [31:0] d,
                      input logic p, input logic [63:0] pd, input logic r,
                      input logic [3:0] ra, input string tag);
    logic [31:0] old [10];
    wrEn = w; wrAddr = a; wrData = d; pairEn = p; pairData = pd; rotEn = r; rdAddr = ra;
    @(posedge clk);
    for (int k = 0; k < 10; k++) old[k] = model[k];
    if (r) begin
      for (int k = 0; k < 4; k++) begin
        model[2+k] = old[2 + ((k+1) % 4)];
        model[6+k] = old[6 + ((k+1) % 4)];
      end
    end
    if (p) begin
      model[0] = pd[63:32];
      model[1] = pd[31:0];
    end
    if (w && !p && !r && a < 4'd6) model[a] = d;
    modelErr = w && (p || r);
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    modelReset();
    @(negedge clk);
    compareAll("R1");          // during reset
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1");          // after release

    // R2: load every writable word; R10 seen at the next falling edge
    for (int k = 0; k < 6; k++)
      step(1, 4'(k), 32'hA5000000 + 32'(k*17), 0, '0, 0, 4'(k), "R2");
    step(1, 4'd3, 32'hDEADBEEF, 0, '0, 0, 4'd3, "R10");

    // R3: high addresses ignored, no flag
    for (int k = 6; k < 16; k++)
      step(1, 4'(k), 32'hFFFF0000 | 32'(k), 0, '0, 0, 4'(k), "R3");

    // R4
    step(0, 4'd0, '0, 1, 64'h1122334455667788, 0, 4'd0, "R4");
    step(0, 4'd0, '0, 1, 64'hCAFEF00D0BADC0DE, 0, 4'd1, "R4");

    // R5 / R6: four rotations return to the start
    for (int k = 0; k < 4; k++) step(0, 4'd0, '0, 0, '0, 1, 4'(2+k), "R5");
    for (int k = 0; k < 4; k++) step(0, 4'd0, '0, 0, '0, 1, 4'(6+k), "R6");

    // R7
    step(0, 4'd0, '0, 1, 64'h0F0F0F0FF0F0F0F0, 1, 4'd0, "R7");

    // R8
    step(1, 4'd0, 32'h12345678, 1, 64'hAAAAAAAA55555555, 0, 4'd0, "R8");
    step(1, 4'd4, 32'h87654321, 1, 64'h0000000100000002, 0, 4'd4, "R8");
    step(0, 4'd0, '0, 0, '0, 0, 4'd0, "R8");

    // R9: dropped even inside and outside the rotating groups
    step(1, 4'd2, 32'h13579BDF, 0, '0, 1, 4'd2, "R9");
    step(1, 4'd0, 32'h2468ACE0, 0, '0, 1, 4'd0, "R9");
    step(1, 4'd12, 32'h11111111, 0, '0, 1, 4'd9, "R9");
    step(1, 4'd1, 32'h22222222, 1, 64'h3333333344444444, 1, 4'd1, "R9");
    step(0, 4'd0, '0, 0, '0, 0, 4'd5, "R9");

    // R11: read port walked without a clock edge
    for (int k = 0; k < 16; k++) begin
      rdAddr = 4'(k);
      #1;
      chk("R11", $sformatf("rd%0d", k), rdData, expRead(4'(k)));
    end

    // Random mix of all requests
    for (int i = 0; i < 400; i++)
      step(($urandom % 3) == 0, 4'($urandom), $urandom, ($urandom % 4) == 0,
           {$urandom, $urandom}, ($urandom % 4) == 0, 4'($urandom), "R7");

    // R12: reset after activity
    for (int k = 0; k < 3; k++) step(0, 4'd0, '0, 0, '0, 1, 4'd7, "R12");
    wrEn = 0; pairEn = 0; rotEn = 0;
    rstN = 1'b0;
    modelReset();
    @(negedge clk);
    compareAll("R12");
    rstN = 1'b1;
    step(0, 4'd0, '0, 0, '0, 0, 4'd8, "R12");

    report();
  end
endmodule